// File: doc/BRIEF.md
# Deflection Router Side Buffer

This block adds a small first-in first-out side path to a bufferless deflection router. It watches the router's post-arbitration outputs. When a flit has lost arbitration and is about to be deflected, the block can pull it off that output, at most one flit per cycle, and hold it. Later it puts the held flit back into the router at the injection stage, using the first pipeline slot it finds empty.

Flits that carry the global forward-progress priority (golden flits) are never taken off an output and never pulled into the buffer. A buffered flit can stall because the injection stage stays full. To prevent this, a wait timer tracks how long the head entry has been blocked. Once the limit is reached, the block swaps the head with the incoming flit in a slot chosen by an external pseudo-random index. The head takes that slot and the displaced flit joins the tail of the buffer, all in the same cycle.

The router keeps route computation, arbitration and ejection. This block only adjusts valid bits on the arbitration side and valid bits and payloads on the injection side.

Top module: `defl_side_buf`

## Requirements
- R1: Among output ports that are valid, flagged deflected and not golden, the lowest-numbered port's flit is captured into the buffer and its valid bit is cleared on `arb_vld_o`. All other ports pass through unchanged, so at most one flit is removed per cycle.
- R2: A golden flit is never captured from the outputs and never displaced by a forced swap. A forced swap whose selected slot holds a golden flit is held off, and the injection stage passes through untouched.
- R3: The buffer holds DEPTH flits (default 4). While it is full, no capture takes place and every deflected flit stays valid on `arb_vld_o`.
- R4: While the buffer is not empty and at least one injection slot is empty, the head flit is placed into the lowest-numbered empty slot and removed from the buffer. Flits leave in the order in which they entered.
- R5: A wait counter clears when the buffer is empty or the head leaves. It otherwise counts cycles in which the head is blocked. When it has reached CTHRESH (default 2), a forced swap fires, so the head leaves on the third consecutive fully occupied cycle with the defaults.
- R6: In a forced swap, the slot indexed by `rnd_i` (port number, 0 = lowest) is valid on `inj_vld_o` and carries the head flit. The flit that arrived in that slot is appended to the buffer and later re-injected like any other entry.
- R7: At most one flit enters the buffer per cycle. In a cycle where a forced swap fires, no capture from the outputs is made.
- R8: After reset the buffer is empty, and both stages pass their inputs through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_vld_i | input | N | Valid per output port after arbitration |
| arb_flit_i | input | N*W | Flit payload per output port, port 0 in the low bits |
| arb_defl_i | input | N | Flit on this output is being deflected |
| arb_gold_i | input | N | Flit on this output is golden |
| arb_vld_o | output | N | Output valid after removal of a captured flit |
| inj_vld_i | input | N | Valid per injection-stage slot |
| inj_flit_i | input | N*W | Flit payload per injection slot |
| inj_gold_i | input | N | Flit in this injection slot is golden |
| rnd_i | input | SELW | Pseudo-random slot index used by a forced swap |
| inj_vld_o | output | N | Injection slot valid after re-injection or swap |
| inj_flit_o | output | N*W | Injection slot payload after re-injection or swap |

## Verification
The bench targets capture priority when several ports deflect at once, including a golden flit on a lower port. A design that picked the wrong port, or took the golden flit, would clear the wrong valid bit. It fills the buffer to capacity and then offers one more deflected flit: a design that overflows would swallow that flit and later replay a corrupted order. It counts the blocked cycles before a forced swap and checks that a design firing early or late moves the head into the random slot on the wrong cycle. It also checks that a swap aimed at a golden slot is held, and that a capture offered in the swap cycle is refused, since a design that pushed twice would lose a flit.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // Width of an index able to name one of n ports (at least one bit).
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  // Width of a counter able to hold the value n.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sbuf_prio_pick.sv
module sbuf_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt_oh,
  output logic         any
);
  // Lowest-numbered request wins; a carry chain of "already granted".
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar p = 0; p < N; p++) begin : g_chain
    assign gnt_oh[p]    = req[p] & ~taken[p];
    assign taken[p + 1] = taken[p] | req[p];
  end
  assign any = taken[N];
endmodule

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 push,
  input  logic [W-1:0]                         push_data,
  input  logic                                 pop,
  output logic [W-1:0]                         head,
  output logic [sbuf_pkg::cnt_width(DEPTH)-1:0] count,
  output logic                                 full,
  output logic                                 empty
);
  localparam int AW = sbuf_pkg::sel_width(DEPTH);
  localparam int CW = sbuf_pkg::cnt_width(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] ptr);
    return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
  endfunction

  always_comb begin
    rd_d  = pop  ? bump(rd_q) : rd_q;
    wr_d  = push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage: no reset, written only under the push enable.
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/sbuf_wait_timer.sv
module sbuf_wait_timer #(
  parameter int CTHRESH = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  have_head,
  input  logic                                  head_left,
  output logic                                  expired,
  output logic [sbuf_pkg::cnt_width(CTHRESH)-1:0] wait_cnt
);
  localparam int TW = sbuf_pkg::cnt_width(CTHRESH);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == TW'(CTHRESH));

  always_comb begin
    cnt_d = cnt_q;
    if (!have_head || head_left) cnt_d = '0;
    else if (!expired)           cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wait_cnt = cnt_q;
endmodule

// File: rtl/defl_side_buf.sv
module defl_side_buf #(
  parameter int N       = 4,
  parameter int W       = 16,
  parameter int DEPTH   = 4,
  parameter int CTHRESH = 2,
  localparam int SELW   = sbuf_pkg::sel_width(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    arb_vld_i,
  input  logic [N*W-1:0]  arb_flit_i,
  input  logic [N-1:0]    arb_defl_i,
  input  logic [N-1:0]    arb_gold_i,
  output logic [N-1:0]    arb_vld_o,
  input  logic [N-1:0]    inj_vld_i,
  input  logic [N*W-1:0]  inj_flit_i,
  input  logic [N-1:0]    inj_gold_i,
  input  logic [SELW-1:0] rnd_i,
  output logic [N-1:0]    inj_vld_o,
  output logic [N*W-1:0]  inj_flit_o
);
  localparam int CW = sbuf_pkg::cnt_width(DEPTH);
  localparam int TW = sbuf_pkg::cnt_width(CTHRESH);

  // Arbitration side: candidates for capture.
  logic [N-1:0] cap_req, cap_oh;
  logic         cap_any, cap_en;
  assign cap_req = arb_vld_i & arb_defl_i & ~arb_gold_i;

  sbuf_prio_pick #(.N(N)) cap_pick_i (.req(cap_req), .gnt_oh(cap_oh), .any(cap_any));

  // Injection side: empty slots.
  logic [N-1:0] hole_oh;
  logic         hole_any;
  sbuf_prio_pick #(.N(N)) hole_pick_i (.req(~inj_vld_i), .gnt_oh(hole_oh), .any(hole_any));

  // Forced swap target from the random index.
  logic [N-1:0] force_oh;
  for (genvar p = 0; p < N; p++) begin : g_force
    assign force_oh[p] = (rnd_i == SELW'(p));
  end

  logic [W-1:0]  head;
  logic [CW-1:0] cnt;
  logic          full, empty;
  logic          expired;
  logic [TW-1:0] wait_cnt;
  logic          reinj, force_ok, pop, push;
  logic [W-1:0]  push_data, cap_flit, force_flit;

  always_comb begin
    cap_flit   = '0;
    force_flit = '0;
    for (int p = 0; p < N; p++) begin
      if (cap_oh[p])   cap_flit   = cap_flit   | arb_flit_i[p*W +: W];
      if (force_oh[p]) force_flit = force_flit | inj_flit_i[p*W +: W];
    end
  end

  always_comb begin
    reinj     = !empty && hole_any;
    force_ok  = !empty && !hole_any && expired &&
                (|(force_oh & inj_vld_i & ~inj_gold_i));
    pop       = reinj || force_ok;
    cap_en    = cap_any && !full && !force_ok;
    push      = cap_en || force_ok;
    push_data = force_ok ? force_flit : cap_flit;
  end

  sbuf_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(push_data),
    .pop      (pop),
    .head     (head),
    .count    (cnt),
    .full     (full),
    .empty    (empty)
  );

  sbuf_wait_timer #(.CTHRESH(CTHRESH)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .have_head(!empty),
    .head_left(pop),
    .expired  (expired),
    .wait_cnt (wait_cnt)
  );

  assign arb_vld_o = arb_vld_i & ~(cap_en ? cap_oh : '0);

  always_comb begin
    inj_vld_o  = inj_vld_i;
    inj_flit_o = inj_flit_i;
    for (int p = 0; p < N; p++) begin
      if ((reinj && hole_oh[p]) || (force_ok && force_oh[p])) begin
        inj_vld_o[p]          = 1'b1;
        inj_flit_o[p*W +: W]  = head;
      end
    end
  end
endmodule

// File: rtl/defl_side_buf_chk.sv
module defl_side_buf_chk #(
  parameter int N       = 4,
  parameter int DEPTH   = 4,
  parameter int CTHRESH = 2,
  parameter int CW      = 3,
  parameter int TW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  arb_vld_i,
  input logic [N-1:0]  arb_gold_i,
  input logic [N-1:0]  arb_vld_o,
  input logic [N-1:0]  inj_vld_i,
  input logic [N-1:0]  inj_vld_o,
  input logic [CW-1:0] cnt,
  input logic [TW-1:0] wait_cnt
);
  // R1: no more than one flit removed from the outputs per cycle
  a_r1_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(arb_vld_i & ~arb_vld_o) <= 1);
  // R1: the block never adds a flit on the output side
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_vld_o & ~arb_vld_i) == '0);
  // R2: a golden output flit always stays valid
  a_r2_gold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((arb_vld_i & arb_gold_i) & ~arb_vld_o) == '0);
  // R3: occupancy never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4: an occupied injection slot is never dropped
  a_r4_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld_i & ~inj_vld_o) == '0);
  // R5: the wait counter never passes the threshold
  a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= TW'(CTHRESH));
  // R8: an empty buffer leaves the injection slots untouched
  a_r8_empty_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (inj_vld_o == inj_vld_i));
endmodule

bind defl_side_buf defl_side_buf_chk #(
  .N(N), .DEPTH(DEPTH), .CTHRESH(CTHRESH),
  .CW(sbuf_pkg::cnt_width(DEPTH)), .TW(sbuf_pkg::cnt_width(CTHRESH))
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .arb_vld_i(arb_vld_i), .arb_gold_i(arb_gold_i), .arb_vld_o(arb_vld_o),
  .inj_vld_i(inj_vld_i), .inj_vld_o(inj_vld_o),
  .cnt(cnt), .wait_cnt(wait_cnt)
);

// File: tb/defl_side_buf_tb_top.sv
module defl_side_buf_tb_top;
  localparam int N = 4;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic [N-1:0]   arb_vld_i, arb_defl_i, arb_gold_i, arb_vld_o;
  logic [N*W-1:0] arb_flit_i;
  logic [N-1:0]   inj_vld_i, inj_gold_i, inj_vld_o;
  logic [N*W-1:0] inj_flit_i, inj_flit_o;
  logic [1:0]     rnd_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  defl_side_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .arb_vld_i(arb_vld_i), .arb_flit_i(arb_flit_i), .arb_defl_i(arb_defl_i),
    .arb_gold_i(arb_gold_i), .arb_vld_o(arb_vld_o),
    .inj_vld_i(inj_vld_i), .inj_flit_i(inj_flit_i), .inj_gold_i(inj_gold_i),
    .rnd_i(rnd_i), .inj_vld_o(inj_vld_o), .inj_flit_o(inj_flit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] islot(input int p);
    return inj_flit_o[p*W +: W];
  endfunction

  // Inject-side flits: slot p carries 16'hC0 + p.
  task automatic idle_inputs();
    arb_vld_i  = '0; arb_defl_i = '0; arb_gold_i = '0; arb_flit_i = '0;
    inj_vld_i  = '0; inj_gold_i = '0; rnd_i = '0;
    for (int p = 0; p < N; p++) inj_flit_i[p*W +: W] = W'(16'hC0 + p);
  endtask

  // Drive at the falling edge, sample 1 ns later (before the rising edge).
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
    arb_vld_i = 4'b1010; arb_defl_i = 4'b0000; inj_vld_i = 4'b0101;
    #1;
    chk("R8 arb passthrough", 32'(arb_vld_o), 32'h0000000A);
    chk("R8 inj passthrough", 32'(inj_vld_o), 32'h00000005);
    chk("R8 inj data", 32'(islot(1)), 32'h000000C1);
  endtask

  task automatic t_capture_lowest();
    step();
    idle_inputs();
    arb_vld_i = 4'b1010; arb_defl_i = 4'b1010;
    arb_flit_i[1*W +: W] = 16'h1111; arb_flit_i[3*W +: W] = 16'h3333;
    inj_vld_i = 4'b1111;
    #1;
    chk("R1 lowest deflected removed", 32'(arb_vld_o), 32'h00000008);
    step();
    idle_inputs();
    inj_vld_i = 4'b0011;
    #1;
    chk("R4 hole filled", 32'(inj_vld_o), 32'h00000007);
    chk("R4 reinjected data", 32'(islot(2)), 32'h00001111);
    step();
    idle_inputs();
    #1;
    chk("R4 buffer drained", 32'(inj_vld_o), 32'h00000000);
  endtask

  task automatic t_golden_skip();
    step();
    idle_inputs();
    arb_vld_i = 4'b0101; arb_defl_i = 4'b0101; arb_gold_i = 4'b0001;
    arb_flit_i[0] = 1'b0;
    arb_flit_i[0*W +: W] = 16'h0BAD; arb_flit_i[2*W +: W] = 16'h2222;
    inj_vld_i = 4'b1111;
    #1;
    chk("R2 golden kept, port2 taken", 32'(arb_vld_o), 32'h00000001);
    step();
    idle_inputs();
    #1;
    chk("R2 non-golden flit re-injected", 32'(islot(0)), 32'h00002222);
    chk("R4 lowest hole used", 32'(inj_vld_o), 32'h00000001);
  endtask

  task automatic t_full_and_order();
    for (int k = 0; k < 5; k++) begin
      step();
      idle_inputs();
      arb_vld_i = 4'b0001; arb_defl_i = 4'b0001;
      arb_flit_i[0 +: W] = W'(16'hA0 + k);
      inj_vld_i = 4'b1111; inj_gold_i = 4'b1111; rnd_i = 2'd1;
      #1;
      if (k < 4) chk("R3 capture below depth", 32'(arb_vld_o), 32'h00000000);
      else begin
        chk("R3 full refuses capture", 32'(arb_vld_o), 32'h00000001);
        chk("R2 golden slot not swapped", 32'(islot(1)), 32'h000000C1);
      end
    end
    for (int k = 0; k < 4; k++) begin
      step();
      idle_inputs();
      #1;
      chk("R4 fifo order", 32'(islot(0)), 32'(16'hA0 + k));
    end
    step();
    idle_inputs();
    #1;
    chk("R3 no fifth entry", 32'(inj_vld_o), 32'h00000000);
  endtask

  task automatic t_forced_swap();
    step();
    idle_inputs();
    arb_vld_i = 4'b0001; arb_defl_i = 4'b0001; arb_flit_i[0 +: W] = 16'h0055;
    inj_vld_i = 4'b1111; rnd_i = 2'd2;
    #1;
    chk("R1 capture for swap test", 32'(arb_vld_o), 32'h00000000);
    for (int k = 0; k < 2; k++) begin
      step();
      idle_inputs();
      inj_vld_i = 4'b1111; rnd_i = 2'd2;
      #1;
      chk("R5 no swap before threshold", 32'(islot(2)), 32'h000000C2);
    end
    step();
    idle_inputs();
    inj_vld_i = 4'b1111; rnd_i = 2'd2;
    arb_vld_i = 4'b0001; arb_defl_i = 4'b0001; arb_flit_i[0 +: W] = 16'h0077;
    #1;
    chk("R6 head in random slot", 32'(islot(2)), 32'h00000055);
    chk("R6 all slots valid", 32'(inj_vld_o), 32'h0000000F);
    chk("R7 no capture during swap", 32'(arb_vld_o), 32'h00000001);
    chk("R6 other slot untouched", 32'(islot(1)), 32'h000000C1);
    step();
    idle_inputs();
    #1;
    chk("R6 displaced flit re-injected", 32'(islot(0)), 32'h000000C2);
    step();
    idle_inputs();
    #1;
    chk("R7 only one entry remained", 32'(inj_vld_o), 32'h00000000);
  endtask

  task automatic t_golden_hold();
    step();
    idle_inputs();
    arb_vld_i = 4'b0010; arb_defl_i = 4'b0010; arb_flit_i[1*W +: W] = 16'h0066;
    inj_vld_i = 4'b1111;
    #1;
    for (int k = 0; k < 4; k++) begin
      step();
      idle_inputs();
      inj_vld_i = 4'b1111; inj_gold_i = 4'b0100; rnd_i = 2'd2;
      #1;
      chk("R2 swap into golden slot held", 32'(islot(2)), 32'h000000C2);
    end
    step();
    idle_inputs();
    inj_vld_i = 4'b1011;
    #1;
    chk("R4 held head leaves via hole", 32'(islot(2)), 32'h00000066);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_capture_lowest();
    t_golden_skip();
    t_full_and_order();
    t_forced_swap();
    t_golden_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule